// File: doc/BRIEF.md
# Reset-Latched Boot Mode and Bus Clock Selector

This block decides, once per reset, whether the chip comes up in debug-monitor mode and which bus clock divider it will use. When the active-low reset pin is released, it freezes the state of a high-voltage detect flag, a group of mode straps and a clock-select strap. All later strap activity is ignored until the next reset.

After release, the block produces a bus clock enable: a single-cycle pulse in the core clock domain. The pulse rate comes from the selected source. It is one pulse every two oscillator strobes, every four oscillator strobes, or every four PLL strobes. The oscillator and the PLL outputs reach the block as one-cycle strobes marking their rising edges, so no derived clock is ever built. The block also watches a hold strap that must stay low for a fixed number of bus cycles after release, and records any breach in a sticky flag.

Top module: `boot_strap_ctrl`

## Requirements
- R1: The straps are sampled on every core clock while `rst_n_i` is low, after `SYNC_STAGES` synchronizer flops; the value sampled last before release is kept. `mon_mode_o` is 1 after release exactly when `hv_irq_i` was 1 and `mode_strap_i` equalled `ENTRY_PAT` (default 3'b101) in that sample.
- R2: While `rst_n_i` stays high, `mon_mode_o`, `clk_sel_o` and the bus enable rate do not change when `hv_irq_i`, `mode_strap_i` or `clk_sel_strap_i` change.
- R3: In monitor mode `clk_sel_o` equals the sampled `clk_sel_strap_i`. In normal mode (entry not met) `clk_sel_o` is forced to 1.
- R4: With `clk_sel_o` = 0, `bus_en_o` pulses once per two `osc_tick_i` strobes.
- R5: With `clk_sel_o` = 1 and `pll_engage_i` = 0, `bus_en_o` pulses once per four `osc_tick_i` strobes.
- R6: With `clk_sel_o` = 1 and `pll_engage_i` = 1, `bus_en_o` pulses once per four `pll_tick_i` strobes.
- R7: With `clk_sel_o` = 0, `pll_engage_i` is ignored and the divide-by-two oscillator rate stays in force.
- R8: `bus_en_o` is low during reset. It is a one-cycle pulse in the cycle after a qualifying source strobe. The divider count restarts at reset release.
- R9: If `hold_strap_i` is high in any cycle before the `HOLD_CYC`-th (default 24th) `bus_en_o` pulse after release has been counted (that pulse's cycle included), `strap_viol_o` rises in the next cycle and stays high until reset.
- R10: `hold_strap_i` high after the `HOLD_CYC`-th bus pulse has no effect on `strap_viol_o`.
- R11: Reset drives `strap_viol_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Reset pin, active low; release latches the boot choice |
| hv_irq_i | input | 1 | Elevated voltage detected on the interrupt pin |
| mode_strap_i | input | STRAP_W | Monitor-entry mode straps |
| clk_sel_strap_i | input | 1 | Clock-select strap (0: osc/2, 1: osc/4 or PLL/4) |
| pll_engage_i | input | 1 | Control bit requesting the PLL source |
| hold_strap_i | input | 1 | Strap that must stay low during the post-reset window |
| osc_tick_i | input | 1 | One-cycle strobe per buffered oscillator edge |
| pll_tick_i | input | 1 | One-cycle strobe per PLL output edge |
| mon_mode_o | output | 1 | Latched monitor-mode flag |
| clk_sel_o | output | 1 | Latched clock-select value |
| bus_en_o | output | 1 | Bus clock enable pulse |
| strap_viol_o | output | 1 | Sticky hold-window violation flag |

## Verification
The oscillator strobe repeats every 3 core cycles and the PLL strobe every 2. The three legal rates therefore give bus pulse spacings of 6, 12 and 8 cycles, so a single measured spacing tells which source and divider are live. Entry is tried with the full pattern and the high-voltage flag, with the flag missing, and with one strap wrong, which separates the monitor case from normal mode and its forced divide-by-four. Straps toggled and PLL requests made after release, under a low select, must leave the spacing at 6. The hold window is probed early, in the cycle of the last counted pulse, and in the cycle after it, which places its closing edge exactly.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;

  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_PLL = 1'b1
  } bus_src_e;

  typedef struct packed {
    logic mon;
    logic sel;
  } boot_cfg_t;

  // Entry decision from one strap sample
  function automatic logic entry_match(input logic hv, input logic [7:0] strap,
                                       input logic [7:0] pat, input int unsigned w);
    logic ok;
    ok = hv;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(w) && strap[i] != pat[i]) ok = 1'b0;
    end
    return ok;
  endfunction

  // Resolved boot configuration: normal mode forces the slow divider
  function automatic boot_cfg_t resolve_cfg(input logic mon, input logic sel_strap);
    boot_cfg_t c;
    c.mon = mon;
    c.sel = mon ? sel_strap : 1'b1;
    return c;
  endfunction

  // Terminal count of the source strobe divider
  function automatic int unsigned div_last(input logic sel, input int unsigned lo,
                                           input int unsigned hi);
    return sel ? (hi - 1) : (lo - 1);
  endfunction

  // Source choice: PLL only when the latched select allows it
  function automatic bus_src_e pick_src(input logic pll_req, input logic sel);
    return (pll_req && sel) ? SRC_PLL : SRC_OSC;
  endfunction

endpackage

// File: rtl/bsc_strap_latch.sv
module bsc_strap_latch
  import boot_strap_pkg::*;
#(
  parameter int unsigned STRAP_W     = 3,
  parameter logic [STRAP_W-1:0] ENTRY_PAT = 3'b101,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hv,
  input  logic [STRAP_W-1:0] strap,
  input  logic               sel_strap,
  output boot_cfg_t          cfg
);

  localparam int unsigned BUS_W = STRAP_W + 2;

  logic [BUS_W-1:0] raw_bus;
  logic [BUS_W-1:0] syn_bus;

  assign raw_bus = {hv, sel_strap, strap};

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign syn_bus = raw_bus;
    end else begin : g_sync
      logic [BUS_W-1:0] stage_q [SYNC_STAGES];
      always_ff @(posedge clk) begin
        stage_q[0] <= raw_bus;
        for (int s = 1; s < int'(SYNC_STAGES); s++) begin
          stage_q[s] <= stage_q[s-1];
        end
      end
      assign syn_bus = stage_q[SYNC_STAGES-1];
    end
  endgenerate

  logic [7:0] strap_ext;
  logic [7:0] pat_ext;
  logic       entry_ok;
  boot_cfg_t  cfg_next;
  boot_cfg_t  cfg_q;

  always_comb begin
    strap_ext = '0;
    pat_ext   = '0;
    strap_ext[STRAP_W-1:0] = syn_bus[STRAP_W-1:0];
    pat_ext[STRAP_W-1:0]   = ENTRY_PAT;
  end

  assign entry_ok = entry_match(syn_bus[BUS_W-1], strap_ext, pat_ext, STRAP_W);
  assign cfg_next = resolve_cfg(entry_ok, syn_bus[STRAP_W]);

  // Loads only while reset is held; frozen from release onward
  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= cfg_next;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/bsc_bus_div.sv
module bsc_bus_div
  import boot_strap_pkg::*;
#(
  parameter int unsigned DIV_LO = 2,
  parameter int unsigned DIV_HI = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic pll_tick,
  input  logic pll_req,
  input  logic sel,
  output logic src_tick,
  output logic pll_on,
  output logic bus_en
);

  localparam int unsigned CNT_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;

  bus_src_e         src;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             wrap;
  logic             bus_en_q;

  assign src      = pick_src(pll_req, sel);
  assign pll_on   = (src == SRC_PLL);
  assign src_tick = pll_on ? pll_tick : osc_tick;
  assign last     = CNT_W'(div_last(sel, DIV_LO, DIV_HI));
  assign wrap     = (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      bus_en_q <= 1'b0;
    end else begin
      bus_en_q <= src_tick && wrap;
      if (src_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign bus_en = bus_en_q;

endmodule

// File: rtl/bsc_hold_window.sv
module bsc_hold_window #(
  parameter int unsigned HOLD_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en,
  input  logic hold,
  output logic win_open,
  output logic viol
);

  localparam int unsigned WC_W = $clog2(HOLD_CYC + 1);
  localparam logic [WC_W-1:0] WC_END = WC_W'(HOLD_CYC);

  logic [WC_W-1:0] wcnt_q;
  logic            viol_q;

  assign win_open = (wcnt_q < WC_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      viol_q <= 1'b0;
    end else begin
      if (bus_en && win_open) wcnt_q <= wcnt_q + 1'b1;
      if (win_open && hold) viol_q <= 1'b1;
    end
  end

  assign viol = viol_q;

endmodule

// File: rtl/boot_strap_ctrl.sv
module boot_strap_ctrl
  import boot_strap_pkg::*;
#(
  parameter int unsigned STRAP_W     = 3,
  parameter logic [STRAP_W-1:0] ENTRY_PAT = 3'b101,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_LO      = 2,
  parameter int unsigned DIV_HI      = 4,
  parameter int unsigned HOLD_CYC    = 24
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               hv_irq_i,
  input  logic [STRAP_W-1:0] mode_strap_i,
  input  logic               clk_sel_strap_i,
  input  logic               pll_engage_i,
  input  logic               hold_strap_i,
  input  logic               osc_tick_i,
  input  logic               pll_tick_i,
  output logic               mon_mode_o,
  output logic               clk_sel_o,
  output logic               bus_en_o,
  output logic               strap_viol_o
);

  boot_cfg_t cfg;
  logic      src_tick;
  logic      pll_on;
  logic      win_open;

  bsc_strap_latch #(
    .STRAP_W    (STRAP_W),
    .ENTRY_PAT  (ENTRY_PAT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_latch (
    .clk      (clk_i),
    .rst_n    (rst_n_i),
    .hv       (hv_irq_i),
    .strap    (mode_strap_i),
    .sel_strap(clk_sel_strap_i),
    .cfg      (cfg)
  );

  bsc_bus_div #(
    .DIV_LO(DIV_LO),
    .DIV_HI(DIV_HI)
  ) u_div (
    .clk     (clk_i),
    .rst_n   (rst_n_i),
    .osc_tick(osc_tick_i),
    .pll_tick(pll_tick_i),
    .pll_req (pll_engage_i),
    .sel     (cfg.sel),
    .src_tick(src_tick),
    .pll_on  (pll_on),
    .bus_en  (bus_en_o)
  );

  bsc_hold_window #(
    .HOLD_CYC(HOLD_CYC)
  ) u_hold (
    .clk     (clk_i),
    .rst_n   (rst_n_i),
    .bus_en  (bus_en_o),
    .hold    (hold_strap_i),
    .win_open(win_open),
    .viol    (strap_viol_o)
  );

  assign mon_mode_o = cfg.mon;
  assign clk_sel_o  = cfg.sel;

endmodule

// File: rtl/boot_strap_ctrl_chk.sv
module boot_strap_ctrl_chk #(
  parameter int unsigned HOLD_CYC = 24
) (
  input logic clk_i,
  input logic rst_n_i,
  input logic mon_mode_o,
  input logic clk_sel_o,
  input logic bus_en_o,
  input logic strap_viol_o,
  input logic hold_strap_i,
  input logic win_open,
  input logic pll_on,
  input logic src_tick
);

  localparam int unsigned CC_W = $clog2(HOLD_CYC + 1);

  logic [CC_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) seen_q <= '0;
    else if (bus_en_o && seen_q < CC_W'(HOLD_CYC)) seen_q <= seen_q + 1'b1;
  end

  assert_cfg_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $past(rst_n_i) |-> ($stable(mon_mode_o) && $stable(clk_sel_o)));

  assert_normal_slow_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !mon_mode_o |-> clk_sel_o);

  assert_pll_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !clk_sel_o |-> !pll_on);

  assert_bus_single_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    bus_en_o |=> !bus_en_o);

  assert_bus_after_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    bus_en_o |-> $past(src_tick));

  assert_window_count_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    win_open == (seen_q < CC_W'(HOLD_CYC)));

  assert_viol_set_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (win_open && hold_strap_i) |=> strap_viol_o);

  assert_viol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    strap_viol_o |=> strap_viol_o);

  assert_late_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!win_open && !strap_viol_o) |=> !strap_viol_o);

  always @(posedge clk_i) begin
    if (!rst_n_i) begin
      assert_reset_clear_R11: assert (!strap_viol_o && !bus_en_o)
        else $error("reset did not clear outputs");
    end
  end

endmodule

bind boot_strap_ctrl boot_strap_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .mon_mode_o  (mon_mode_o),
  .clk_sel_o   (clk_sel_o),
  .bus_en_o    (bus_en_o),
  .strap_viol_o(strap_viol_o),
  .hold_strap_i(hold_strap_i),
  .win_open    (win_open),
  .pll_on      (pll_on),
  .src_tick    (src_tick)
);

// File: tb/boot_strap_ctrl_bench.sv
`timescale 1ns/1ps
module boot_strap_ctrl_bench;

  logic       clk_i = 1'b0;
  logic       rst_n_i = 1'b0;
  logic       hv_irq_i = 1'b0;
  logic [2:0] mode_strap_i = 3'b000;
  logic       clk_sel_strap_i = 1'b0;
  logic       pll_engage_i = 1'b0;
  logic       hold_strap_i = 1'b0;
  logic       osc_tick_i = 1'b0;
  logic       pll_tick_i = 1'b0;
  logic       mon_mode_o;
  logic       clk_sel_o;
  logic       bus_en_o;
  logic       strap_viol_o;

  boot_strap_ctrl u_boot_strap_ctrl (
    .clk_i          (clk_i),
    .rst_n_i        (rst_n_i),
    .hv_irq_i       (hv_irq_i),
    .mode_strap_i   (mode_strap_i),
    .clk_sel_strap_i(clk_sel_strap_i),
    .pll_engage_i   (pll_engage_i),
    .hold_strap_i   (hold_strap_i),
    .osc_tick_i     (osc_tick_i),
    .pll_tick_i     (pll_tick_i),
    .mon_mode_o     (mon_mode_o),
    .clk_sel_o      (clk_sel_o),
    .bus_en_o       (bus_en_o),
    .strap_viol_o   (strap_viol_o)
  );

  always #2 clk_i = ~clk_i;   // 250 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int osc_ph = 0;
  int pll_ph = 0;
  bit done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  // Source strobes: oscillator every 3 cycles, PLL every 2
  always @(negedge clk_i) begin
    osc_ph = (osc_ph + 1) % 3;
    pll_ph = (pll_ph + 1) % 2;
    osc_tick_i <= (osc_ph == 0);
    pll_tick_i <= (pll_ph == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Scoreboard: expected pulse spacings and their requirement tags
  int    exp_q[$];
  string tag_q[$];
  bit    resync = 1'b1;
  int    last_cyc = 0;
  bit    last_ok = 1'b0;

  always @(negedge clk_i) begin
    if (!rst_n_i) begin
      last_ok = 1'b0;
    end else if (bus_en_o) begin
      if (last_ok && !resync && exp_q.size() > 0) begin
        chk(tag_q.pop_front(), cyc - last_cyc, exp_q.pop_front());
      end
      resync   = 1'b0;
      last_cyc = cyc;
      last_ok  = 1'b1;
    end
  end

  task automatic expect_spacing(input string req, input int n, input int per);
    resync = 1'b1;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(per);
      tag_q.push_back(req);
    end
    for (int t = 0; t < 400 && exp_q.size() > 0; t++) @(negedge clk_i);
    chk({req, " spacing queue drained"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic do_reset(input bit hv, input logic [2:0] st, input bit sel, input bit pll);
    @(negedge clk_i);
    rst_n_i = 1'b0;
    hv_irq_i = hv;
    mode_strap_i = st;
    clk_sel_strap_i = sel;
    pll_engage_i = pll;
    hold_strap_i = 1'b0;
    repeat (8) @(negedge clk_i);
    chk("R8 bus enable low in reset", int'(bus_en_o), 0);
    chk("R11 violation clear in reset", int'(strap_viol_o), 0);
    rst_n_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wait_pulses(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk_i);
      if (bus_en_o) seen++;
    end
  endtask

  initial begin
    // Monitor entry, fast divider
    do_reset(1'b1, 3'b101, 1'b0, 1'b0);
    chk("R1 monitor entered", int'(mon_mode_o), 1);
    chk("R3 select follows strap", int'(clk_sel_o), 0);
    expect_spacing("R4 osc/2", 3, 6);
    hv_irq_i = 1'b0; mode_strap_i = 3'b010; clk_sel_strap_i = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R2 mode frozen", int'(mon_mode_o), 1);
    chk("R2 select frozen", int'(clk_sel_o), 0);
    expect_spacing("R2 rate frozen", 2, 6);
    pll_engage_i = 1'b1;
    expect_spacing("R7 PLL request ignored", 3, 6);

    // Monitor entry, slow divider, then PLL
    do_reset(1'b1, 3'b101, 1'b1, 1'b0);
    chk("R1 monitor entered slow", int'(mon_mode_o), 1);
    chk("R3 select high", int'(clk_sel_o), 1);
    expect_spacing("R5 osc/4", 3, 12);
    pll_engage_i = 1'b1;
    expect_spacing("R6 PLL/4 engaged", 3, 8);
    pll_engage_i = 1'b0;
    expect_spacing("R5 osc/4 after PLL off", 2, 12);

    // No high voltage: normal mode
    do_reset(1'b0, 3'b101, 1'b0, 1'b0);
    chk("R1 no entry without HV", int'(mon_mode_o), 0);
    chk("R3 normal forces select", int'(clk_sel_o), 1);
    expect_spacing("R3 normal osc/4", 2, 12);

    // Wrong pattern
    do_reset(1'b1, 3'b100, 1'b0, 1'b0);
    chk("R1 no entry on wrong pattern", int'(mon_mode_o), 0);

    // PLL requested through reset
    do_reset(1'b1, 3'b101, 1'b1, 1'b1);
    expect_spacing("R6 PLL/4 from release", 3, 8);

    // Early violation, sticky
    do_reset(1'b1, 3'b101, 1'b0, 1'b0);
    repeat (5) @(negedge clk_i);
    hold_strap_i = 1'b1;
    @(negedge clk_i);
    hold_strap_i = 1'b0;
    @(negedge clk_i);
    chk("R9 early hold flagged", int'(strap_viol_o), 1);
    repeat (300) @(negedge clk_i);
    chk("R9 flag sticky", int'(strap_viol_o), 1);

    // Last counted pulse cycle still inside window
    do_reset(1'b1, 3'b101, 1'b0, 1'b0);
    chk("R11 flag cleared by reset", int'(strap_viol_o), 0);
    wait_pulses(24);
    hold_strap_i = 1'b1;
    @(negedge clk_i);
    hold_strap_i = 1'b0;
    @(negedge clk_i);
    chk("R9 hold at last pulse flagged", int'(strap_viol_o), 1);

    // One cycle later the window is closed
    do_reset(1'b1, 3'b101, 1'b0, 1'b0);
    wait_pulses(24);
    @(negedge clk_i);
    hold_strap_i = 1'b1;
    repeat (5) @(negedge clk_i);
    hold_strap_i = 1'b0;
    @(negedge clk_i);
    chk("R10 late hold ignored", int'(strap_viol_o), 0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end

endmodule